// File: doc/BRIEF.md
# Retrace Interrupter and Control Register Unit

This unit is the register and interrupt side of a frame-buffer slave on a VME-style bus. A decoded select picks the single 16-bit register slot. A write loads the write-only control word: an 8-bit interrupt vector, an enable for the retrace interrupt, and a video blank bit. A read returns the 4-bit board configuration status. Address decoding and the electrical bus drivers are outside the unit.

When the retrace interrupt is enabled and a vertical-retrace-start pulse arrives, the unit raises one of seven request lines, chosen by a level input. The request stays up until an acknowledge cycle claims it or software clears the enable. During an acknowledge cycle whose level matches, the unit presents its vector and holds back the daisy chain. For any other acknowledge cycle it passes the incoming chain signal on to the next board.

System reset clears both enables but leaves the vector register as it was.

Top module: `retrace_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the retrace enable and `video_blank` are 0, no request line is set, and `iack_out` and `vec_valid` are 0.
- R2: A write (`reg_sel`=1, `reg_wr`=1, both strobes set) loads the vector from `reg_wdata[7:0]`, the retrace enable from bit 8 and the blank control from bit 9, and ignores bits 15:10. `reg_ack` is 1 in the cycle after the access.
- R3: `video_blank` equals control bit 9 as last written.
- R4: A `retrace_start` pulse while the enable is 1 sets the request on exactly one line, `irq_lines[irq_level-1]`. When `irq_level` is 0, no line is set.
- R5: An acknowledge cycle claims the request when `iack_in` rises with `iack_level` equal to `irq_level` and a request pending. In the next cycle `vec_valid` is 1 and `vec_data` holds the vector, and `iack_out` stays 0 until `iack_in` falls.
- R6: A read with both strobes returns `cfg_pins` in `reg_rdata[3:0]` and zeros in bits 15:4 in the cycle after the access, with `reg_ack`=1.
- R7: A pending request holds until it is claimed or a write clears bit 8. It is dropped in the cycle after either event.
- R8: An acknowledge cycle that is not claimed (level mismatch or nothing pending) copies `iack_in` to `iack_out` one cycle later, and `vec_valid` stays 0.
- R9: A `retrace_start` pulse while the enable is 0 raises no request.
- R10: An access without both strobes set changes no register and gives no `reg_ack`.
- R11: Reset does not change the vector; `vec_data` shows the same value before and after reset.
- R12: If a retrace pulse and a claim fall in the same cycle, the request is set again for the new frame. If a retrace pulse and a write clearing the enable fall in the same cycle, no request results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| reg_sel | input | 1 | Decoded select of the register slot |
| reg_wr | input | 1 | 1 = write access, 0 = read access |
| reg_strb | input | 2 | Byte strobes; both must be set |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (status) |
| reg_ack | output | 1 | Access acknowledge, one cycle after a valid access |
| cfg_pins | input | 4 | Configuration inputs (0 = jumper present) |
| irq_level | input | 3 | Configured request level, 1..7 |
| retrace_start | input | 1 | One-cycle pulse at vertical retrace start |
| irq_lines | output | 7 | Request lines; bit n is level n+1 |
| iack_in | input | 1 | Incoming acknowledge daisy chain |
| iack_level | input | 3 | Level being acknowledged |
| iack_out | output | 1 | Outgoing acknowledge daisy chain |
| vec_valid | output | 1 | Drive enable for the vector byte |
| vec_data | output | 8 | Interrupt vector held in the control register |
| video_blank | output | 1 | Video output blanked when 1 |

## Verification
The retrace pulse can arrive in the same cycle as an acknowledge claim, or in the same cycle as a control write that clears the enable. Both collisions change the next request state.

The bench provokes each collision by driving both stimuli at one falling edge. It then judges the result one cycle later at the ports. After the first collision the vector is delivered and the request line stays set. After the second, the request line stays clear.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned STRB_W    = DATA_W / 8;
    localparam int unsigned VEC_W     = 8;
    localparam int unsigned CFG_W     = 4;
    localparam int unsigned IEN_BIT   = 8;
    localparam int unsigned BLANK_BIT = 9;

    typedef struct packed {
        logic              ien;
        logic              blank;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } regs_state_t;

    typedef struct packed {
        logic pending;
    } src_state_t;

    typedef struct packed {
        logic iack_prev;
        logic own;
        logic fwd;
    } ack_state_t;
endpackage

// File: rtl/rirq_regs.sv
module rirq_regs
    import rirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [STRB_W-1:0] strb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CFG_W-1:0]  cfg_pins,
    output logic [VEC_W-1:0]  vec,
    output logic              ien,
    output logic              blank,
    output logic              ien_clr,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    regs_state_t      st_d, st_q;
    logic [VEC_W-1:0] vec_d, vec_q;
    logic             full, do_wr, do_rd;
    logic             wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:BLANK_BIT+1];

    always_comb begin
        full  = &strb;
        do_wr = sel && wr && full;
        do_rd = sel && !wr && full;
        st_d  = st_q;
        vec_d = vec_q;
        st_d.ack   = do_wr || do_rd;
        st_d.rdata = '0;
        if (do_rd) begin
            st_d.rdata[CFG_W-1:0] = cfg_pins;
        end
        if (do_wr) begin
            vec_d      = wdata[VEC_W-1:0];
            st_d.ien   = wdata[IEN_BIT];
            st_d.blank = wdata[BLANK_BIT];
        end
    end

    assign ien_clr = do_wr && !wdata[IEN_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11: the vector has no reset
    always_ff @(posedge clk) begin
        vec_q <= vec_d;
    end

    assign vec   = vec_q;
    assign ien   = st_q.ien;
    assign blank = st_q.blank;
    assign ack   = st_q.ack;
    assign rdata = st_q.rdata;

    // R10
    partial_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !(&strb)) |=> !ack);
    // R2
    write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && (&strb)) |=> (ien == $past(wdata[IEN_BIT])) && (blank == $past(wdata[BLANK_BIT])) && ack);
    // R6
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:CFG_W] == '0);
endmodule

// File: rtl/rirq_source.sv
module rirq_source #(
    parameter int unsigned NUM_LEVELS = 7,
    parameter int unsigned LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  retrace_start,
    input  logic                  ien,
    input  logic                  ien_clr,
    input  logic                  claim,
    input  logic [LVL_W-1:0]      level,
    output logic                  pending,
    output logic [NUM_LEVELS-1:0] irq_lines
);
    import rirq_pkg::*;

    src_state_t st_d, st_q;
    logic       set_req;

    always_comb begin
        st_d    = st_q;
        set_req = retrace_start && ien && !ien_clr;
        st_d.pending = set_req || (st_q.pending && !claim && !ien_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pending;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_line
        assign irq_lines[g] = st_q.pending && (level == LVL_W'(g + 1));
    end

    // R4
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_lines));
    // R9
    no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien && !pending) |=> !pending);
    // R7
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !claim && !ien_clr) |=> pending);
endmodule

// File: rtl/rirq_ack.sv
module rirq_ack #(
    parameter int unsigned NUM_LEVELS = 7,
    parameter int unsigned LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_in,
    input  logic [LVL_W-1:0] iack_level,
    input  logic [LVL_W-1:0] level,
    input  logic             pending,
    output logic             claim,
    output logic             vec_valid,
    output logic             iack_out
);
    import rirq_pkg::*;

    ack_state_t st_d, st_q;
    logic       rise, lvl_ok;

    always_comb begin
        st_d   = st_q;
        rise   = iack_in && !st_q.iack_prev;
        lvl_ok = (level != '0) && (level <= LVL_W'(NUM_LEVELS));
        claim  = rise && pending && lvl_ok && (iack_level == level);
        st_d.iack_prev = iack_in;
        st_d.own       = iack_in && (rise ? claim : st_q.own);
        st_d.fwd       = iack_in && !st_d.own;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_valid = st_q.own;
    assign iack_out  = st_q.fwd;

    // R5
    claim_blocks_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> (vec_valid && !iack_out));
    // R8
    idle_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_in |=> (!iack_out && !vec_valid));
    // R5
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && iack_out));
endmodule

// File: rtl/retrace_irq_ctrl.sv
module retrace_irq_ctrl
    import rirq_pkg::*;
#(
    parameter int unsigned NUM_LEVELS = 7,
    parameter int unsigned LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_sel,
    input  logic                  reg_wr,
    input  logic [STRB_W-1:0]     reg_strb,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_ack,
    input  logic [CFG_W-1:0]      cfg_pins,
    input  logic [LVL_W-1:0]      irq_level,
    input  logic                  retrace_start,
    output logic [NUM_LEVELS-1:0] irq_lines,
    input  logic                  iack_in,
    input  logic [LVL_W-1:0]      iack_level,
    output logic                  iack_out,
    output logic                  vec_valid,
    output logic [VEC_W-1:0]      vec_data,
    output logic                  video_blank
);
    logic ien, ien_clr, claim, pending;

    rirq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (reg_sel),
        .wr       (reg_wr),
        .strb     (reg_strb),
        .wdata    (reg_wdata),
        .cfg_pins (cfg_pins),
        .vec      (vec_data),
        .ien      (ien),
        .blank    (video_blank),
        .ien_clr  (ien_clr),
        .ack      (reg_ack),
        .rdata    (reg_rdata)
    );

    rirq_source #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_source (
        .clk           (clk),
        .rst_n         (rst_n),
        .retrace_start (retrace_start),
        .ien           (ien),
        .ien_clr       (ien_clr),
        .claim         (claim),
        .level         (irq_level),
        .pending       (pending),
        .irq_lines     (irq_lines)
    );

    rirq_ack #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .iack_in    (iack_in),
        .iack_level (iack_level),
        .level      (irq_level),
        .pending    (pending),
        .claim      (claim),
        .vec_valid  (vec_valid),
        .iack_out   (iack_out)
    );

    // R1
    blank_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(video_blank) |-> $past(reg_sel && reg_wr));
endmodule

// File: tb/test_retrace_irq_ctrl.sv
module test_retrace_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_strb = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_ack;
    logic [3:0]  cfg_pins = 4'hE;
    logic [2:0]  irq_level = 3'd3;
    logic        retrace_start = 1'b0;
    logic [6:0]  irq_lines;
    logic        iack_in = 1'b0;
    logic [2:0]  iack_level = '0;
    logic        iack_out, vec_valid, video_blank;
    logic [7:0]  vec_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    logic       vv_prev = 1'b0;

    always #4 clk = ~clk;

    retrace_irq_ctrl i_retrace_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_strb(reg_strb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_ack(reg_ack), .cfg_pins(cfg_pins), .irq_level(irq_level),
        .retrace_start(retrace_start), .irq_lines(irq_lines),
        .iack_in(iack_in), .iack_level(iack_level), .iack_out(iack_out),
        .vec_valid(vec_valid), .vec_data(vec_data), .video_blank(video_blank)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected vector on each new vector presentation (R5)
    always @(negedge clk) begin
        if (vec_valid && !vv_prev) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected vector", {24'd0, vec_data}, 32'hFFFF_FFFF);
            end else begin
                check("R5 vector", {24'd0, vec_data}, {24'd0, exp_q.pop_front()});
            end
        end
        vv_prev = vec_valid;
    end

    task automatic wr_ctl(input logic [15:0] d, input logic [1:0] s);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_strb = s; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; reg_strb = 2'b00;
    endtask

    task automatic rd_status(output logic [15:0] d, output logic a);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_strb = 2'b11;
        @(negedge clk);
        d = reg_rdata; a = reg_ack;
        reg_sel = 1'b0; reg_strb = 2'b00;
    endtask

    task automatic retrace();
        retrace_start = 1'b1;
        @(negedge clk);
        retrace_start = 1'b0;
    endtask

    // Driver: runs one acknowledge cycle; pushes the expected vector when a claim is due
    task automatic ack_cycle(input logic [2:0] lvl, input logic expect_claim,
                             input logic [7:0] exp_vec, input string req);
        if (expect_claim) exp_q.push_back(exp_vec);
        iack_in = 1'b1; iack_level = lvl;
        @(negedge clk);
        check({req, " iack_out"}, {31'd0, iack_out}, {31'd0, !expect_claim});
        check({req, " vec_valid"}, {31'd0, vec_valid}, {31'd0, expect_claim});
        @(negedge clk);
        iack_in = 1'b0;
        @(negedge clk);
        check({req, " chain idle"}, {30'd0, iack_out, vec_valid}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        ak;
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 blank in reset", {31'd0, video_blank}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 lines after reset", {25'd0, irq_lines}, 32'd0);
        check("R1 chain after reset", {30'd0, iack_out, vec_valid}, 32'd0);
        retrace();
        check("R1 no req with enable reset", {25'd0, irq_lines}, 32'd0);

        // R6: status read, two patterns
        rd_status(rd, ak);
        check("R6 status E", {16'd0, rd}, 32'h000E);
        check("R6 ack", {31'd0, ak}, 32'd1);
        cfg_pins = 4'h5;
        rd_status(rd, ak);
        check("R6 status 5", {16'd0, rd}, 32'h0005);

        // R2 R3: full write, high bits set but ignored
        wr_ctl(16'hFF5A, 2'b11);
        check("R2 write ack", {31'd0, reg_ack}, 32'd1);
        check("R3 blank on", {31'd0, video_blank}, 32'd1);
        check("R2 vector", {24'd0, vec_data}, 32'h5A);

        // R10: partial writes ignored
        wr_ctl(16'h0000, 2'b01);
        check("R10 no ack", {31'd0, reg_ack}, 32'd0);
        wr_ctl(16'h0000, 2'b10);
        check("R10 blank kept", {31'd0, video_blank}, 32'd1);
        check("R10 vector kept", {24'd0, vec_data}, 32'h5A);

        // R4: request on level 3 line
        retrace();
        check("R4 line level3", {25'd0, irq_lines}, 32'h04);
        // R8: mismatched level passes chain, request stays
        ack_cycle(3'd5, 1'b0, 8'h00, "R8 mismatch");
        check("R7 held after mismatch", {25'd0, irq_lines}, 32'h04);
        // R5 R7: matching claim releases the request
        ack_cycle(3'd3, 1'b1, 8'h5A, "R5 claim");
        check("R7 released after claim", {25'd0, irq_lines}, 32'h00);
        // R8: nothing pending -> chain passes
        ack_cycle(3'd3, 1'b0, 8'h00, "R8 none pending");

        // R4: level 7 and level 0
        irq_level = 3'd7;
        wr_ctl(16'h0166, 2'b11);
        check("R3 blank off", {31'd0, video_blank}, 32'd0);
        retrace();
        check("R4 line level7", {25'd0, irq_lines}, 32'h40);
        irq_level = 3'd0;
        @(negedge clk);
        check("R4 level0 no line", {25'd0, irq_lines}, 32'h00);
        irq_level = 3'd7;

        // R7: clearing enable drops pending; R9: retrace while disabled
        wr_ctl(16'h0066, 2'b11);
        check("R7 cleared by enable", {25'd0, irq_lines}, 32'h00);
        retrace();
        check("R9 no req disabled", {25'd0, irq_lines}, 32'h00);

        // R12a: retrace coincides with claim
        wr_ctl(16'h0177, 2'b11);
        retrace();
        exp_q.push_back(8'h77);
        iack_in = 1'b1; iack_level = 3'd7; retrace_start = 1'b1;
        @(negedge clk);
        retrace_start = 1'b0;
        check("R12 vector strobe", {31'd0, vec_valid}, 32'd1);
        check("R12 rearmed line", {25'd0, irq_lines}, 32'h40);
        iack_in = 1'b0;
        @(negedge clk);
        // R12b: retrace coincides with enable clear (nothing pending first)
        ack_cycle(3'd7, 1'b1, 8'h77, "R5 second claim");
        wr_ctl(16'h0177, 2'b11);
        retrace_start = 1'b1;
        wr_ctl(16'h0077, 2'b11);
        retrace_start = 1'b0;
        check("R12 clear wins", {25'd0, irq_lines}, 32'h00);

        // R11: vector survives reset, enables cleared
        wr_ctl(16'h03A5, 2'b11);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 vector kept", {24'd0, vec_data}, 32'hA5);
        check("R1 blank cleared", {31'd0, video_blank}, 32'd0);
        retrace();
        check("R1 enable cleared", {25'd0, irq_lines}, 32'h00);

        check("R5 scoreboard drained", exp_q.size(), 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule